// File: doc/BRIEF.md
# DMA Channel Descriptor Chain Controller

This block keeps the control state of a single DMA channel and walks a linked list of descriptors held in memory. A CPU programs the channel through a small register port. Writing a nonzero value to the link register arms chaining and starts a transfer. An external transfer engine reports the outcome with a one-cycle done pulse or a one-cycle error pulse. When a transfer completes normally and chaining is armed, the block reads the next descriptor through a simple request/acknowledge memory port. It loads the descriptor into its registers and starts the channel again.

The channel has eight 32-bit registers. Index 0 is the link (next descriptor address), 1 is the source address, 2 is the destination address, 3 is the byte count, 4 is control, and 5 to 7 are auxiliary words. A short descriptor reloads indices 0 to 3. A full descriptor reloads all eight. Descriptor word k is read from link + 4*k, with k counting up from 0.

Top module: `dma_chain_ctl`

## Requirements
- R1: After reset, `active`, `chain_en`, `cfg_err` and `mem_req` are 0, and every register reads 0.
- R2: A CPU write of a nonzero value to index 0 sets `chain_en`, and starts the channel (`active` = 1 one cycle later) if the configuration is legal. A zero write to index 0 clears `chain_en` and leaves `active` unchanged.
- R3: A done pulse while `active` is 1 and `chain_en` is 0 clears `active`, and no descriptor read follows.
- R4: A done pulse while `active` and `chain_en` are both 1 starts a descriptor read. Word k is requested at link + 4*k in ascending order. `mem_req` and `mem_addr` hold steady until `mem_ack`.
- R5: Control bit 5 (short mode) set means a descriptor read fetches four words, and indices 4 to 7 keep their values. Control bit 5 clear means eight words are fetched and written to indices 0 to 7.
- R6: After the last descriptor word, the channel restarts (`active` = 1) with the loaded values. `chain_en` then equals (loaded link != 0).
- R7: An error pulse while `active` is 1 clears `active`, and no descriptor read follows.
- R8: Control bits 4:2 are the unit size. Code 011 is illegal. Codes 110 and 111 are illegal unless control bit 0 (single-address) is 1. A start attempt with an illegal size sets `cfg_err` and leaves `active` at 0. A legal start clears `cfg_err`.
- R9: `dir_m2io` equals control bit 1 when control bit 0 is 1, and is 0 otherwise.
- R10: A CPU write to index 4 with bit 6 set aborts any state. One cycle later, `active`, `mem_req`, `chain_en` and `cfg_err` are 0.
- R11: While `master_en` is 0, `chain_en` is cleared on the next edge.
- R12: Reading index 4 returns control bits 5:0, a 0 at bit 6, `active` at bit 8 and `chain_en` at bit 9. A write to index 4 with bit 8 set starts the channel. Every other index reads back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | Global enable; low clears chaining |
| reg_wr | input | 1 | CPU register write strobe |
| reg_addr | input | 3 | CPU register index |
| reg_wdata | input | 32 | CPU write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Descriptor word request |
| mem_addr | output | 32 | Descriptor word address |
| mem_ack | input | 1 | Memory returns `mem_rdata` this cycle |
| mem_rdata | input | 32 | Descriptor word data |
| xfer_done | input | 1 | Engine reports normal completion |
| xfer_err | input | 1 | Engine reports a failed transfer |
| active | output | 1 | Transfer in progress |
| chain_en | output | 1 | Chaining armed |
| cfg_err | output | 1 | Last start attempt had an illegal size |
| chain_addr | output | 32 | Link register |
| src_addr | output | 32 | Source address register |
| dst_addr | output | 32 | Destination address register |
| xfer_count | output | 32 | Count register |
| xfer_size | output | 3 | Unit size code |
| single_mode | output | 1 | Single-address mode |
| dir_m2io | output | 1 | Effective memory-to-I/O direction |

## Verification
The bound checker watches the following on every cycle:
- a channel reset leaves the block idle,
- an error or an unchained completion leads to idle with no request,
- a pending request holds its address,
- `cfg_err` never coincides with `active`,
- the dual-address direction is masked,
- a master-enable drop disarms chaining.

Only the bench scenarios can show the rest:
- the exact fetch addresses and their order,
- which registers a short or a full descriptor overwrites,
- that a two-hop chain ends when a zero link is loaded,
- that a loaded illegal size refuses to restart.

// File: rtl/dma_chain_ctl.sv
module dma_chain_ctl #(
  parameter int W       = 32,
  parameter int NFULL   = 8,
  parameter int NSHORT  = 4,
  localparam int IW     = $clog2(NFULL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_en,
  input  logic          reg_wr,
  input  logic [IW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  output logic          mem_req,
  output logic [W-1:0]  mem_addr,
  input  logic          mem_ack,
  input  logic [W-1:0]  mem_rdata,
  input  logic          xfer_done,
  input  logic          xfer_err,
  output logic          active,
  output logic          chain_en,
  output logic          cfg_err,
  output logic [W-1:0]  chain_addr,
  output logic [W-1:0]  src_addr,
  output logic [W-1:0]  dst_addr,
  output logic [W-1:0]  xfer_count,
  output logic [2:0]    xfer_size,
  output logic          single_mode,
  output logic          dir_m2io
);
  localparam int SH = $clog2(W/8);
  localparam logic [IW-1:0] LINK_IX = IW'(0);
  localparam logic [IW-1:0] CTRL_IX = IW'(4);

  typedef enum logic [1:0] {S_IDLE, S_ACTIVE, S_FETCH, S_RESTART} st_t;

  st_t           st;
  logic [W-1:0]  r [NFULL];
  logic [IW-1:0] idx;
  logic [W-1:0]  base;
  logic          full_q, chain_q, err_q;

  function automatic logic [W-1:0] fit(input logic [IW-1:0] i, input logic [W-1:0] d);
    fit = (i == CTRL_IX) ? {{(W-6){1'b0}}, d[5:0]} : d;
  endfunction

  function automatic logic legal(input logic [5:0] c);
    legal = (c[4:2] != 3'b011) && !(c[4] && c[3] && !c[0]);
  endfunction

  wire [5:0] cfg      = r[CTRL_IX][5:0];
  wire       ctrl_wr  = reg_wr && (reg_addr == CTRL_IX);
  wire       ch_rst   = ctrl_wr && reg_wdata[6];
  wire       link_wr  = reg_wr && (reg_addr == LINK_IX);
  wire       go       = (link_wr && (reg_wdata != '0)) || (ctrl_wr && reg_wdata[8]);
  wire [5:0] next_cfg = ctrl_wr ? reg_wdata[5:0] : cfg;
  wire       take     = (st == S_FETCH) && mem_ack && !ch_rst;
  wire [IW-1:0] last  = full_q ? IW'(NFULL-1) : IW'(NSHORT-1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      for (int i = 0; i < NFULL; i++) r[i] <= '0;
      idx     <= '0;
      base    <= '0;
      full_q  <= 1'b0;
      chain_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (reg_wr) r[reg_addr] <= fit(reg_addr, reg_wdata);
      if (take)   r[idx]      <= fit(idx, mem_rdata);

      if (!master_en || ch_rst)          chain_q <= 1'b0;
      else if (take && idx == LINK_IX)   chain_q <= |mem_rdata;
      else if (link_wr)                  chain_q <= |reg_wdata;

      if (ch_rst) begin
        st    <= S_IDLE;
        err_q <= 1'b0;
        idx   <= '0;
      end else begin
        case (st)
          S_IDLE:
            if (go) begin
              st    <= legal(next_cfg) ? S_ACTIVE : S_IDLE;
              err_q <= !legal(next_cfg);
            end
          S_ACTIVE:
            if (xfer_err) st <= S_IDLE;
            else if (xfer_done) begin
              if (chain_q) begin
                st     <= S_FETCH;
                idx    <= '0;
                base   <= r[LINK_IX];
                full_q <= !cfg[5];
              end else st <= S_IDLE;
            end
          S_FETCH:
            if (mem_ack) begin
              if (idx == last) st <= S_RESTART;
              else idx <= idx + 1'b1;
            end
          S_RESTART: begin
            st    <= legal(cfg) ? S_ACTIVE : S_IDLE;
            err_q <= !legal(cfg);
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign active      = (st == S_ACTIVE);
  assign mem_req     = (st == S_FETCH);
  assign mem_addr    = base + (W'(idx) << SH);
  assign chain_en    = chain_q;
  assign cfg_err     = err_q;
  assign chain_addr  = r[0];
  assign src_addr    = r[1];
  assign dst_addr    = r[2];
  assign xfer_count  = r[3];
  assign xfer_size   = cfg[4:2];
  assign single_mode = cfg[0];
  assign dir_m2io    = cfg[0] & cfg[1];
  assign reg_rdata   = (reg_addr == CTRL_IX)
                     ? {{(W-10){1'b0}}, chain_q, active, 2'b00, cfg}
                     : r[reg_addr];
endmodule

// File: rtl/dma_chain_ctl_chk.sv
module dma_chain_ctl_chk #(
  parameter int W  = 32,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          master_en,
  input logic          reg_wr,
  input logic [IW-1:0] reg_addr,
  input logic [W-1:0]  reg_wdata,
  input logic          mem_req,
  input logic [W-1:0]  mem_addr,
  input logic          mem_ack,
  input logic          xfer_done,
  input logic          xfer_err,
  input logic          active,
  input logic          chain_en,
  input logic          cfg_err,
  input logic [W-1:0]  chain_addr,
  input logic          single_mode,
  input logic          dir_m2io
);
  wire rst_wr  = reg_wr && (reg_addr == IW'(4)) && reg_wdata[6];
  wire zero_wr = reg_wr && (reg_addr == IW'(0)) && (reg_wdata == '0);

  AST_CHAN_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_wr |=> !active && !mem_req && !chain_en && !cfg_err); // R10
  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    active && xfer_err |=> !active && !mem_req); // R7
  AST_DONE_UNCHAINED: assert property (@(posedge clk) disable iff (!rst_n)
    active && xfer_done && !chain_en |=> !active && !mem_req); // R3
  AST_DONE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    active && xfer_done && !xfer_err && chain_en && !rst_wr
      |=> mem_req && mem_addr == $past(chain_addr)); // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !rst_wr |=> mem_req && $stable(mem_addr)); // R4
  AST_MASTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |=> !chain_en); // R11
  AST_ZERO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    zero_wr && !mem_req |=> !chain_en); // R2
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !active); // R8
  AST_DUAL_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    !single_mode |-> !dir_m2io); // R9
endmodule

bind dma_chain_ctl dma_chain_ctl_chk #(.W(W), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .master_en(master_en), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .xfer_done(xfer_done),
  .xfer_err(xfer_err), .active(active), .chain_en(chain_en),
  .cfg_err(cfg_err), .chain_addr(chain_addr), .single_mode(single_mode),
  .dir_m2io(dir_m2io)
);

// File: tb/tb_dma_chain_ctl.sv
module tb_dma_chain_ctl;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, master_en = 1;
  logic reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_req, mem_ack = 0;
  logic [31:0] mem_addr, mem_rdata = 0;
  logic xfer_done = 0, xfer_err = 0;
  logic active, chain_en, cfg_err, single_mode, dir_m2io;
  logic [31:0] chain_addr, src_addr, dst_addr, xfer_count;
  logic [2:0] xfer_size;

  dma_chain_ctl dut (.*);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [31:0] mem [64];
  logic [31:0] lg [64];
  int nlog = 0;

  // size, single, expected active, expected cfg_err, expected dir (m2io written as 1)
  localparam logic [6:0] VEC [16] = '{
    7'b000_0_100, 7'b000_1_101, 7'b001_0_100, 7'b001_1_101,
    7'b010_0_100, 7'b010_1_101, 7'b011_0_010, 7'b011_1_011,
    7'b100_0_100, 7'b100_1_101, 7'b101_0_100, 7'b101_1_101,
    7'b110_0_010, 7'b110_1_101, 7'b111_0_010, 7'b111_1_101};

  function automatic logic [31:0] look(input logic [31:0] a);
    if (a >= 32'h100 && a < 32'h200) look = mem[(a - 32'h100) >> 2];
    else look = 32'hDEAD0000 | a;
  endfunction

  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack = 1;
      mem_rdata = look(mem_addr);
      lg[nlog % 64] = mem_addr;
      nlog = nlog + 1;
    end else mem_ack = 0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse(input bit err);
    @(negedge clk); if (err) xfer_err = 1; else xfer_done = 1;
    @(negedge clk); xfer_err = 0; xfer_done = 0;
  endtask

  task automatic wait_act(input string req);
    int n = 0;
    while (!active && n < 80) begin @(negedge clk); n++; end
    chk(req, active, 1);
  endtask

  task automatic idle_for(input string req, input int base);
    logic seen = 0;
    repeat (4) begin @(negedge clk); if (mem_req) seen = 1; end
    chk(req, {seen, active}, 0);
    chk(req, nlog - base, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int b;
    for (int i = 0; i < 64; i++) mem[i] = 0;
    mem[0] = 0; mem[1] = 32'h1111; mem[2] = 32'h2222; mem[3] = 32'h33;
    mem[4] = 32'h7; mem[5] = 32'hBEEF1; mem[6] = 32'hBEEF2; mem[7] = 32'hBEEF3;
    mem[16] = 32'h180; mem[17] = 32'hA1; mem[18] = 32'hA2; mem[19] = 32'hA3;
    mem[20] = 32'h03; mem[21] = 32'hC1; mem[22] = 32'hC2; mem[23] = 32'hC3;
    mem[32] = 0; mem[33] = 32'hB1; mem[34] = 32'hB2; mem[35] = 32'hB3;
    mem[36] = 32'h05; mem[37] = 32'hD1; mem[38] = 32'hD2; mem[39] = 32'hD3;
    mem[48] = 0; mem[49] = 32'hE1; mem[50] = 32'hE2; mem[51] = 32'hE3;
    mem[52] = 32'h0C;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 flags", {active, chain_en, cfg_err, mem_req}, 0);
    chk("R1 src", src_addr, 0);
    rd(3'd4, d); chk("R1 ctrl", d, 0);
    rd(3'd6, d); chk("R1 aux", d, 0);

    // R8 R9 R2 size legality table
    for (int i = 0; i < 16; i++) begin
      wr(3'd4, 32'h40);
      wr(3'd4, {27'd0, VEC[i][6:4], 1'b1, VEC[i][3]});
      wr(3'd0, 32'h1F0);
      chk("R2 R8 start", active, {31'd0, VEC[i][2]});
      chk("R8 cfg_err", cfg_err, {31'd0, VEC[i][1]});
      chk("R9 dir", dir_m2io, {31'd0, VEC[i][0]});
      chk("R2 chain_en", chain_en, 1);
    end

    // R12 readback, R2 zero link while active, R3 unchained done
    wr(3'd4, 32'h40);
    wr(3'd1, 32'h12345678);
    rd(3'd1, d); chk("R12 src readback", d, 32'h12345678);
    wr(3'd4, 32'h37);
    wr(3'd0, 32'h1F0);
    rd(3'd4, d); chk("R12 ctrl layout", d, 32'h337);
    wr(3'd0, 32'h0);
    chk("R2 zero link", {chain_en, active}, 32'h1);
    b = nlog;
    pulse(0);
    idle_for("R3 no fetch", b);

    // R12 start by control go bit
    wr(3'd4, 32'h40);
    wr(3'd4, 32'h100);
    chk("R12 go bit", {active, chain_en}, 32'h2);
    wr(3'd4, 32'h40);

    // R4 R5 R6 short descriptor
    wr(3'd5, 32'hA5A5);
    wr(3'd4, 32'h28);
    wr(3'd0, 32'h100);
    chk("R2 chain start", {active, chain_en}, 32'h3);
    b = nlog;
    pulse(0);
    wait_act("R6 restart short");
    chk("R5 short words", nlog - b, 4);
    for (int k = 0; k < 4; k++) chk("R4 order short", lg[(b + k) % 64], 32'h100 + 32'(4 * k));
    chk("R6 src", src_addr, 32'h1111);
    chk("R6 dst", dst_addr, 32'h2222);
    chk("R6 count", xfer_count, 32'h33);
    chk("R6 chain_en off", chain_en, 0);
    rd(3'd5, d); chk("R5 aux kept", d, 32'hA5A5);
    rd(3'd4, d); chk("R5 ctrl kept", d, 32'h128);
    b = nlog;
    pulse(0);
    idle_for("R3 end of chain", b);

    // R4 R5 R6 full descriptors, two hops
    wr(3'd4, 32'h40);
    wr(3'd4, 32'h0);
    wr(3'd0, 32'h140);
    b = nlog;
    pulse(0);
    wait_act("R6 restart hop1");
    chk("R5 full words", nlog - b, 8);
    for (int k = 0; k < 8; k++) chk("R4 order full", lg[(b + k) % 64], 32'h140 + 32'(4 * k));
    chk("R6 chain_en hop1", chain_en, 1);
    chk("R6 src hop1", src_addr, 32'hA1);
    chk("R9 dir loaded", dir_m2io, 1);
    rd(3'd7, d); chk("R5 aux loaded", d, 32'hC3);
    b = nlog;
    pulse(0);
    wait_act("R6 restart hop2");
    chk("R4 hop2 first addr", lg[b % 64], 32'h180);
    chk("R6 src hop2", src_addr, 32'hB1);
    chk("R6 chain_en hop2", chain_en, 0);
    rd(3'd4, d); chk("R12 ctrl hop2", d, 32'h105);
    chk("R9 dir hop2", dir_m2io, 0);
    b = nlog;
    pulse(0);
    idle_for("R3 after hop2", b);

    // R7 error pulse
    wr(3'd4, 32'h40);
    wr(3'd4, 32'h0);
    wr(3'd0, 32'h140);
    b = nlog;
    pulse(1);
    idle_for("R7 error stop", b);

    // R8 illegal size loaded by descriptor, then legal start clears it
    wr(3'd4, 32'h40);
    wr(3'd4, 32'h0);
    wr(3'd0, 32'h1C0);
    b = nlog;
    pulse(0);
    for (int n = 0; n < 80 && (nlog - b) < 8; n++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R8 loaded illegal", {cfg_err, active}, 32'h2);
    chk("R6 src loaded", src_addr, 32'hE1);
    wr(3'd4, 32'h100);
    chk("R8 legal clears", {cfg_err, active}, 32'h1);

    // R10 channel reset during fetch
    wr(3'd4, 32'h40);
    wr(3'd4, 32'h0);
    wr(3'd0, 32'h140);
    pulse(0);
    for (int n = 0; n < 20 && !mem_req; n++) @(negedge clk);
    chk("R10 fetching", mem_req, 1);
    wr(3'd4, 32'h40);
    chk("R10 abort", {mem_req, active, chain_en, cfg_err}, 0);
    b = nlog;
    idle_for("R10 stays idle", b);

    // R11 master enable drop
    wr(3'd0, 32'h140);
    chk("R11 armed", {active, chain_en}, 32'h3);
    @(negedge clk); master_en = 0;
    @(negedge clk); master_en = 1;
    chk("R11 disarmed", chain_en, 0);
    b = nlog;
    pulse(0);
    idle_for("R11 no fetch", b);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule